// File: doc/BRIEF.md
# Glitch-Free Clock Group Stop and Power-Down Sequencer

This block sits behind the clock sources of a system clock generator. It gates two groups of clocks: a set of processor clocks and a set of peripheral-bus clocks. It also passes one free-running peripheral-bus reference clock that only a power-down can silence. Each group has an active-low stop request, and a single active-low power-down input overrides both. The peripheral-bus group and the free-running output share one source clock. The processor group has its own source.

Every request is first resynchronised by two flops clocked on rising edges of the free-running reference. The enable of each group is then reloaded only on a falling edge of that group's own source clock, and the output is the source ANDed with the enable. A clock can therefore stop or restart only while it is low. Every high phase that leaves the block has full width, and stopped clocks rest at logic low.

When power-down is released, or reset is removed, a settling counter runs for a time derived from a reference frequency parameter and a settling time parameter (3 ms by default). During that time all outputs stay low. When the counter expires, a ready flag rises and the clocks are released.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `cpu_stop_n` is low (and power is up), every bit of `cpu_clk_o` is held at 0. Both `pci_clk_o` and `pcif_clk_o` keep toggling.
- R2: While `pci_stop_n` is low (and power is up), every bit of `pci_clk_o` is held at 0. `pcif_clk_o` and `cpu_clk_o` keep toggling.
- R3: Every high pulse on any output has the full high time of its source clock, across stops, restarts and power-down. An enable changes only while its source clock is low.
- R4: A stop or run request is taken on the second rising edge of the reference clock after it changes. The gate then switches at the next falling edge of the affected group's source clock. With a request applied 1 ns after a reference falling edge, and the bench clock phases, this gives the following timing. A CPU stop lets exactly 4 more CPU pulses out. A PCI stop lets exactly 2 more PCI pulses out. A CPU restart shows its first pulse 41 ns after the request, and a PCI restart 49 ns after it.
- R5: While `pwr_dn_n` is low, every output is 0, `pcif_clk_o` included, whatever the stop inputs are. `clk_ready` is also 0.
- R6: With power up, each of the four settings of (`cpu_stop_n`, `pci_stop_n`) runs or stops the two groups independently: a 1 runs the group and a 0 stops it.
- R7: After `pwr_dn_n` rises, or reset is released, `clk_ready` stays 0 for 1+SETTLE_CYCLES rising reference edges and is 1 after the next edge. Here SETTLE_CYCLES = PCIF_KHZ*SETTLE_US/1000. A power-down during settling restarts the count. Outputs stay low until `clk_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| pcif_clk_in | input | 1 | Free-running reference; source for the PCI group and free-running output |
| cpu_clk_in | input | 1 | Source clock of the processor group |
| cpu_stop_n | input | 1 | Active-low stop request for the processor group |
| pci_stop_n | input | 1 | Active-low stop request for the PCI group |
| pwr_dn_n | input | 1 | Active-low power-down |
| cpu_clk_o | output | NCPU | Gated processor clocks |
| pci_clk_o | output | NPCI | Gated PCI clocks |
| pcif_clk_o | output | 1 | Free-running PCI clock, silenced only by power-down |
| clk_ready | output | 1 | Settling finished, clocks released |

## Verification
The gating is driven with each stop input toggled alone. This separates a correct per-group gate from one that couples the groups or touches the free-running output. All four stop settings are then applied in turn to expose any cross-wiring. Requests are placed at a fixed phase, so exact counts of trailing pulses and exact restart delays catch a missing or extra synchroniser stage, or an enable reloaded on the wrong edge. A pulse-width monitor on every group tells a low-phase switch apart from one that clips a high phase. Power-down is applied with the stops in both states, and again in the middle of settling, to show that it overrides the stops and that it restarts the count.

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int NCPU      = 4,
  parameter int NPCI      = 7,
  parameter int PCIF_KHZ  = 33333,
  parameter int SETTLE_US = 3000
) (
  input  logic            rst_n,
  input  logic            pcif_clk_in,
  input  logic            cpu_clk_in,
  input  logic            cpu_stop_n,
  input  logic            pci_stop_n,
  input  logic            pwr_dn_n,
  output logic [NCPU-1:0] cpu_clk_o,
  output logic [NPCI-1:0] pci_clk_o,
  output logic            pcif_clk_o,
  output logic            clk_ready
);
  localparam int SETTLE_RAW    = PCIF_KHZ * SETTLE_US / 1000;
  localparam int SETTLE_CYCLES = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int CW            = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [1:0]    cs_q, ps_q, pd_q;
  logic [CW-1:0] cnt;
  logic          cpu_en, pci_en, pcif_en;

  always_ff @(posedge pcif_clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
      ps_q <= '0;
      pd_q <= '0;
    end else begin
      cs_q <= {cs_q[0], cpu_stop_n};
      ps_q <= {ps_q[0], pci_stop_n};
      pd_q <= {pd_q[0], pwr_dn_n};
    end
  end

  always_ff @(posedge pcif_clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      clk_ready <= 1'b0;
    end else if (!pd_q[1]) begin
      cnt       <= '0;
      clk_ready <= 1'b0;
    end else if (!clk_ready) begin
      if (cnt == LAST) clk_ready <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end

  always_ff @(negedge cpu_clk_in or negedge rst_n) begin
    if (!rst_n) cpu_en <= 1'b0;
    else        cpu_en <= cs_q[1] & clk_ready;
  end

  always_ff @(negedge pcif_clk_in or negedge rst_n) begin
    if (!rst_n) begin
      pci_en  <= 1'b0;
      pcif_en <= 1'b0;
    end else begin
      pci_en  <= ps_q[1] & clk_ready;
      pcif_en <= clk_ready;
    end
  end

  assign cpu_clk_o  = {NCPU{cpu_clk_in & cpu_en}};
  assign pci_clk_o  = {NPCI{pcif_clk_in & pci_en}};
  assign pcif_clk_o = pcif_clk_in & pcif_en;

  always @(cpu_en) if (rst_n) p_cpu_en_low_r3: assert (!cpu_clk_in);
  always @(pci_en) if (rst_n) p_pci_en_low_r3: assert (!pcif_clk_in);
  always @(pcif_en) if (rst_n) p_pcif_en_low_r3: assert (!pcif_clk_in);

  p_cpu_follow_r1: assert property (@(negedge cpu_clk_in) disable iff (!rst_n)
    !cs_q[1] |=> !cpu_en);
  p_pci_follow_r2: assert property (@(negedge pcif_clk_in) disable iff (!rst_n)
    !ps_q[1] |=> !pci_en);
  p_pcif_off_r5: assert property (@(negedge pcif_clk_in) disable iff (!rst_n)
    !clk_ready |=> (!pcif_en && !pci_en));
  p_pd_drops_ready_r5: assert property (@(posedge pcif_clk_in) disable iff (!rst_n)
    !pd_q[1] |=> !clk_ready);
  p_no_overflow_r7: assert property (@(posedge pcif_clk_in) disable iff (!rst_n)
    cnt <= LAST);
  p_ready_after_count_r7: assert property (@(posedge pcif_clk_in) disable iff (!rst_n)
    $rose(clk_ready) |-> ($past(cnt) == LAST));
endmodule

// File: tb/clk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module clk_stop_ctrl_bench;
  localparam int NCPU = 4, NPCI = 7, KHZ = 50000, SUS = 1;
  localparam int SETTLE = KHZ * SUS / 1000;

  logic rst_n = 1'b0, pcif = 1'b0, cpuc = 1'b0;
  logic cstop_n = 1'b1, pstop_n = 1'b1, pd_n = 1'b1;
  logic [NCPU-1:0] cpu_o;
  logic [NPCI-1:0] pci_o;
  logic pcif_o, ready;
  int checks = 0, errors = 0, bad_pulses = 0;
  int n_cpu = 0, n_pci = 0, n_f = 0;
  longint t_cpu = 0, t_pci = 0, t_req = 0;

  clk_stop_ctrl #(.NCPU(NCPU), .NPCI(NPCI), .PCIF_KHZ(KHZ), .SETTLE_US(SUS)) u_clk_stop_ctrl (
    .rst_n(rst_n), .pcif_clk_in(pcif), .cpu_clk_in(cpuc), .cpu_stop_n(cstop_n),
    .pci_stop_n(pstop_n), .pwr_dn_n(pd_n), .cpu_clk_o(cpu_o), .pci_clk_o(pci_o),
    .pcif_clk_o(pcif_o), .clk_ready(ready));

  always #10 pcif = ~pcif;
  initial begin #2; forever begin cpuc = ~cpuc; #5; end end

  always @(posedge cpu_o[0]) begin if (n_cpu == 0) t_cpu = $time; n_cpu++; end
  always @(posedge pci_o[0]) begin if (n_pci == 0) t_pci = $time; n_pci++; end
  always @(posedge pcif_o) n_f++;

  longint r0 = 0, r1 = 0, r2 = 0, r3 = 0;
  always @(posedge cpu_o[0]) r0 = $time;
  always @(negedge cpu_o[0]) if ($time - r0 != 5) begin bad_pulses++; $display("note: short cpu pulse at %0t", $time); end
  always @(posedge pci_o[NPCI-1]) r1 = $time;
  always @(negedge pci_o[NPCI-1]) if ($time - r1 != 10) begin bad_pulses++; $display("note: short pci pulse at %0t", $time); end
  always @(posedge pcif_o) r2 = $time;
  always @(negedge pcif_o) if ($time - r2 != 10) begin bad_pulses++; $display("note: short pcif pulse at %0t", $time); end
  always @(posedge cpu_o[NCPU-1]) r3 = $time;
  always @(negedge cpu_o[NCPU-1]) if ($time - r3 != 5) begin bad_pulses++; $display("note: short cpu pulse at %0t", $time); end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic at_neg(); @(negedge pcif); #1; endtask
  task automatic clear(); n_cpu = 0; n_pci = 0; n_f = 0; t_req = $time; endtask
  task automatic wait_pos(input int n);
    for (int i = 0; i < n; i++) @(posedge pcif);
  endtask

  task automatic t_settle(input string tag);
    wait_pos(1 + SETTLE);
    at_neg();
    chk({tag, " R7 ready still low"}, ready, 0);
    chk({tag, " R7 outputs low while settling"}, {cpu_o, pci_o, pcif_o}, 0);
    @(posedge pcif); #1;
    chk({tag, " R7 ready raised"}, ready, 1);
  endtask

  task automatic t_reset();
    #5;
    chk("R5 reset ready", ready, 0);
    chk("R5 reset outputs", {cpu_o, pci_o, pcif_o}, 0);
    at_neg(); rst_n = 1'b1;
    t_settle("reset");
    wait_pos(3); at_neg(); clear(); wait_pos(4); at_neg();
    chk("R6 cpu runs after reset", n_cpu, 8);
    chk("R6 pci runs after reset", n_pci, 4);
  endtask

  task automatic t_cpu_stop();
    at_neg(); clear(); cstop_n = 1'b0;
    wait_pos(6); at_neg();
    chk("R4 cpu pulses after stop", n_cpu, 4);
    chk("R1 cpu vector low", cpu_o, 0);
    clear(); wait_pos(6); at_neg();
    chk("R1 cpu stays stopped", n_cpu, 0);
    chk("R1 pci keeps running", n_pci, 6);
    chk("R1 pcif keeps running", n_f, 6);
    clear(); cstop_n = 1'b1;
    wait_pos(4); at_neg();
    chk("R4 cpu restart latency", t_cpu - t_req, 41);
  endtask

  task automatic t_pci_stop();
    at_neg(); clear(); pstop_n = 1'b0;
    wait_pos(6); at_neg();
    chk("R4 pci pulses after stop", n_pci, 2);
    chk("R2 pci vector low", pci_o, 0);
    clear(); wait_pos(6); at_neg();
    chk("R2 pci stays stopped", n_pci, 0);
    chk("R2 pcif unaffected", n_f, 6);
    chk("R2 cpu unaffected", n_cpu, 12);
    clear(); pstop_n = 1'b1;
    wait_pos(4); at_neg();
    chk("R4 pci restart latency", t_pci - t_req, 49);
  endtask

  task automatic t_combos();
    for (int k = 0; k < 4; k++) begin
      at_neg(); cstop_n = k[1]; pstop_n = k[0];
      wait_pos(5); at_neg(); clear(); wait_pos(4); at_neg();
      chk($sformatf("R6 combo %0d cpu", k), n_cpu, k[1] ? 8 : 0);
      chk($sformatf("R6 combo %0d pci", k), n_pci, k[0] ? 4 : 0);
      chk($sformatf("R6 combo %0d pcif", k), n_f, 4);
    end
    cstop_n = 1'b1; pstop_n = 1'b1;
    wait_pos(5);
  endtask

  task automatic t_power_down();
    for (int s = 0; s < 2; s++) begin
      at_neg(); cstop_n = s[0]; pstop_n = s[0]; pd_n = 1'b0;
      wait_pos(4); at_neg(); clear(); wait_pos(5); at_neg();
      chk($sformatf("R5 pd stops=%0d cpu", s), n_cpu, 0);
      chk($sformatf("R5 pd stops=%0d pci", s), n_pci, 0);
      chk($sformatf("R5 pd stops=%0d pcif", s), n_f, 0);
      chk($sformatf("R5 pd stops=%0d ready", s), ready, 0);
      pd_n = 1'b1;
      t_settle("pd");
    end
    at_neg(); pd_n = 1'b0; wait_pos(4); at_neg(); pd_n = 1'b1;
    wait_pos(SETTLE / 2); at_neg(); pd_n = 1'b0;
    wait_pos(3); at_neg();
    chk("R7 ready low after aborted settle", ready, 0);
    pd_n = 1'b1;
    t_settle("restart");
    wait_pos(3); at_neg(); clear(); wait_pos(4); at_neg();
    chk("R5 clocks back after pd", n_cpu + n_pci + n_f, 16);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_cpu_stop();
        t_pci_stop();
        t_combos();
        t_power_down();
        chk("R3 full-width high pulses", bad_pulses, 0);
      end
      begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule